// File: doc/BRIEF.md
# SMBus Host Register Front-End

This block sits between a processor-side byte bus and an SMBus bit engine. Software programs a target address, a command byte, up to two data bytes, a PEC byte and a protocol code through byte-wide registers. It then writes the control register with its launch bit set. The block hands one transaction to the bit engine and tracks it in a status register. When the engine reports an outcome, the block records it as a sticky flag, which software clears by writing a one. Software can abort a running transaction, and a data buffer lets block transfers stage their bytes before and after the bus traffic.

A three-state controller sequences every transaction. **Idle** waits for a launch request. A launch written in Idle moves it to **Launch**, which asserts the engine start strobe for exactly one cycle. From Launch it moves to **Wait** unless the engine finishes or software aborts in that same cycle. Both Launch and Wait return to Idle on an engine completion, which records one outcome flag, or on a kill request, which records the failed flag. Busy is high in Launch and in Wait. It falls at the same clock edge that records the outcome.

Top module: `smbh_regfront`

## Requirements
- R1: After reset, every register reads 0x00, the busy flag is low and the engine start and abort strobes are low.
- R2: The registers sit at these offsets: status 0, control 2, command 3, address 4, data0 5, data1 6, block data 7, PEC 8, aux status 12, aux control 13. Command, address, data0, data1 and PEC read back what was written. Control reads back bit 7 (PEC enable) and bits 5:2 (protocol); bits 6 and 1 always read 0. Aux control keeps bit 0 (CRC check enable, driven on `eng_crc_chk`) and bit 1 (buffer enable, driven on `eng_buf32`). The PEC byte is driven on `eng_pec_byte`.
- R3: A control write with bit 6 set and bit 1 clear while idle launches a transaction. Status bit 0 (busy) reads 1 from the next cycle. `eng_start` is high for that one cycle only. During it the engine sees: protocol from control bits 5:2 (0x0 quick, 0x1 byte, 0x2 byte-data, 0x3 word, 0x4 process call, 0x5 block, 0x6 I2C block, 0xD block last byte, 0xE I2C block last byte); PEC enable from bit 7; slave from address bits 7:1; read direction from address bit 0; command and data0.
- R4: An engine completion clears busy at the same edge that sets exactly one outcome flag. The flag follows `eng_result`: 0 gives done (status bit 1), 1 (no acknowledge) gives device error (bit 2), 2 (arbitration lost) gives bus error (bit 3), and 3 (PEC mismatch) gives device error plus aux status bit 0.
- R5: A successful completion with address bit 0 set loads data0 from `eng_rdata0` and data1 from `eng_rdata1`; any other completion leaves both unchanged.
- R6: A control write with bit 1 set while busy pulses `eng_abort` in that cycle. Busy reads 0 from the next cycle, status bit 4 (failed) is set, and a later engine completion changes nothing. The same write while idle sets no flag.
- R7: While busy, writes to control fields, command, address, data0, data1, PEC, aux control and block data are ignored, and a second launch neither restarts the engine nor changes the protocol it sees.
- R8: Status bits 7, 5, 4, 3, 2 and 1 clear only when a one is written to them. Writing zero leaves them unchanged, and a set in the same cycle as its clear wins.
- R9: Status bit 6 (in-use) reads as it was before the read and is set by every status read; writing one to it clears it.
- R10: A high cycle on `alert_in` sets status bit 5.
- R11: A high cycle on `eng_byte_done` sets status bit 7.
- R12: With the buffer enabled, block-data writes and reads step one index per access and wrap at the buffer depth, and a control read rewinds the index to 0. The engine reads any entry through `eng_buf_addr`, and writes entries only while busy. With the buffer disabled, every block-data access uses entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle |
| alert_in | input | 1 | Alert event from the bus |
| eng_start | output | 1 | One-cycle launch strobe to the engine |
| eng_abort | output | 1 | Abort strobe to the engine |
| eng_proto | output | 4 | Protocol code |
| eng_pec_en | output | 1 | PEC enabled for this transaction |
| eng_slave | output | 7 | Target address |
| eng_dir_rd | output | 1 | 1 for a read |
| eng_cmd | output | 8 | Command byte |
| eng_d0 | output | 8 | Data0 |
| eng_d1 | output | 8 | Data1 |
| eng_pec_byte | output | 8 | PEC register |
| eng_crc_chk | output | 1 | CRC check enable |
| eng_buf32 | output | 1 | Buffer enable |
| eng_done | input | 1 | Engine completion strobe |
| eng_result | input | 2 | Outcome with eng_done |
| eng_byte_done | input | 1 | One byte moved |
| eng_rdata0 | input | 8 | Read result low byte |
| eng_rdata1 | input | 8 | Read result high byte |
| eng_buf_addr | input | IDX_W | Engine buffer index |
| eng_buf_we | input | 1 | Engine buffer write |
| eng_buf_wdata | input | 8 | Engine buffer write data |
| eng_buf_rdata | output | 8 | Engine buffer read data |

## Verification
The bench builds the block with an 8-entry buffer, so index wrap-around is reached after eight block-data accesses. It sweeps all nine protocol codes against all four engine outcomes and both transfer directions. Each of these transactions is checked for the launch strobe and operands, the busy edge, the single outcome flag and the read-data capture. Directed sequences then cover kill in both states, writes while busy, write-one-clear races, the in-use semaphore and the buffer in both modes.

// File: rtl/smbh_pkg.sv
package smbh_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_LAUNCH = 2'd1,
        SQ_WAIT   = 2'd2
    } sq_state_t;

    typedef enum logic [1:0] {
        RES_ACK  = 2'd0,
        RES_NACK = 2'd1,
        RES_ARB  = 2'd2,
        RES_PEC  = 2'd3
    } eng_res_t;

    typedef struct packed {
        logic ok;
        logic nack;
        logic arb;
        logic pec;
        logic kill;
    } fin_t;

    localparam logic [3:0] OFS_STAT = 4'd0;
    localparam logic [3:0] OFS_CTL  = 4'd2;
    localparam logic [3:0] OFS_CMD  = 4'd3;
    localparam logic [3:0] OFS_ADR  = 4'd4;
    localparam logic [3:0] OFS_D0   = 4'd5;
    localparam logic [3:0] OFS_D1   = 4'd6;
    localparam logic [3:0] OFS_BLK  = 4'd7;
    localparam logic [3:0] OFS_PEC  = 4'd8;
    localparam logic [3:0] OFS_AXS  = 4'd12;
    localparam logic [3:0] OFS_AXC  = 4'd13;

    localparam int CTL_PEC   = 7;
    localparam int CTL_GO    = 6;
    localparam int CTL_PR_HI = 5;
    localparam int CTL_PR_LO = 2;
    localparam int CTL_KILL  = 1;

    localparam int ST_BDONE = 7;
    localparam int ST_INUSE = 6;
    localparam int ST_ALERT = 5;
    localparam int ST_FAIL  = 4;
    localparam int ST_BUS   = 3;
    localparam int ST_DEV   = 2;
    localparam int ST_DONE  = 1;

endpackage

// File: rtl/smbh_seq.sv
module smbh_seq
    import smbh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_req,
    input  logic       kill_req,
    input  logic       eng_done,
    input  logic [1:0] eng_result,
    output logic       busy,
    output logic       eng_start,
    output logic       eng_abort,
    output fin_t       fin
);

    sq_state_t state_q;
    sq_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (go_req) state_d = SQ_LAUNCH;
            end
            SQ_LAUNCH: begin
                state_d = (kill_req || eng_done) ? SQ_IDLE : SQ_WAIT;
            end
            SQ_WAIT: begin
                if (kill_req || eng_done) state_d = SQ_IDLE;
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    always_comb begin
        busy      = (state_q != SQ_IDLE);
        eng_start = (state_q == SQ_LAUNCH);
        eng_abort = busy && kill_req;
        fin       = '0;
        if (busy && kill_req) begin
            fin.kill = 1'b1;
        end else if (busy && eng_done) begin
            unique case (eng_res_t'(eng_result))
                RES_ACK:  fin.ok   = 1'b1;
                RES_NACK: fin.nack = 1'b1;
                RES_ARB:  fin.arb  = 1'b1;
                RES_PEC:  fin.pec  = 1'b1;
                default:  fin      = '0;
            endcase
        end
    end

    // R6
    kill_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && kill_req) |=> !busy)
        else $error("kill did not stop the transaction");

    // R3
    launch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && go_req) |=> (eng_start && busy))
        else $error("launch request did not start engine");

    // R3
    start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start)
        else $error("start strobe longer than one cycle");

    // R7
    no_relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_WAIT && go_req && !kill_req && !eng_done) |=> (busy && !eng_start))
        else $error("launch while busy restarted the engine");

endmodule

// File: rtl/smbh_buf.sv
module smbh_buf #(
    parameter int DEPTH = 32,
    parameter int IDX_W = 5
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cpu_wr,
    input  logic             cpu_rd,
    input  logic [7:0]       cpu_wdata,
    input  logic             rewind,
    output logic [7:0]       cpu_rdata,
    input  logic [IDX_W-1:0] eng_addr,
    input  logic             eng_we,
    input  logic [7:0]       eng_wdata,
    output logic [7:0]       eng_rdata
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    logic [7:0]       mem [DEPTH];
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] cur_idx;

    assign cur_idx   = en ? idx_q : '0;
    assign cpu_rdata = mem[cur_idx];
    assign eng_rdata = mem[eng_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (rewind || !en) begin
            idx_q <= '0;
        end else if (cpu_wr || cpu_rd) begin
            idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (eng_we) mem[eng_addr] <= eng_wdata;
            if (cpu_wr) mem[cur_idx] <= cpu_wdata;
        end
    end

    // R12
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !rewind && (cpu_wr || cpu_rd)) |=> (idx_q != $past(idx_q)))
        else $error("buffer index did not advance");

endmodule

// File: rtl/smbh_regfront.sv
module smbh_regfront
    import smbh_pkg::*;
#(
    parameter int BUF_DEPTH = 32,
    localparam int IDX_W = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [3:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             alert_in,
    output logic             eng_start,
    output logic             eng_abort,
    output logic [3:0]       eng_proto,
    output logic             eng_pec_en,
    output logic [6:0]       eng_slave,
    output logic             eng_dir_rd,
    output logic [7:0]       eng_cmd,
    output logic [7:0]       eng_d0,
    output logic [7:0]       eng_d1,
    output logic [7:0]       eng_pec_byte,
    output logic             eng_crc_chk,
    output logic             eng_buf32,
    input  logic             eng_done,
    input  logic [1:0]       eng_result,
    input  logic             eng_byte_done,
    input  logic [7:0]       eng_rdata0,
    input  logic [7:0]       eng_rdata1,
    input  logic [IDX_W-1:0] eng_buf_addr,
    input  logic             eng_buf_we,
    input  logic [7:0]       eng_buf_wdata,
    output logic [7:0]       eng_buf_rdata
);

    logic       wr_en;
    logic       rd_en;
    logic       cfg_we;
    logic       busy;
    logic       go_req;
    logic       kill_req;
    fin_t       fin;
    logic [7:0] st_clr;
    logic [7:0] blk_rdata;

    logic [3:0] proto_q;
    logic       pec_en_q;
    logic [7:0] cmd_q;
    logic [7:0] adr_q;
    logic [7:0] d0_q;
    logic [7:0] d1_q;
    logic [7:0] pec_q;
    logic [1:0] axc_q;

    logic st_bd, st_inuse, st_alert, st_fail, st_bus, st_dev, st_done;
    logic axs_pec;

    assign wr_en    = bus_sel && bus_wr;
    assign rd_en    = bus_sel && !bus_wr;
    assign cfg_we   = wr_en && !busy;
    assign go_req   = wr_en && (bus_addr == OFS_CTL) && bus_wdata[CTL_GO] && !bus_wdata[CTL_KILL];
    assign kill_req = wr_en && (bus_addr == OFS_CTL) && bus_wdata[CTL_KILL];
    assign st_clr   = (wr_en && bus_addr == OFS_STAT) ? bus_wdata : 8'h00;

    smbh_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_req     (go_req),
        .kill_req   (kill_req),
        .eng_done   (eng_done),
        .eng_result (eng_result),
        .busy       (busy),
        .eng_start  (eng_start),
        .eng_abort  (eng_abort),
        .fin        (fin)
    );

    smbh_buf #(
        .DEPTH (BUF_DEPTH),
        .IDX_W (IDX_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (axc_q[1]),
        .cpu_wr    (cfg_we && bus_addr == OFS_BLK),
        .cpu_rd    (rd_en && bus_addr == OFS_BLK),
        .cpu_wdata (bus_wdata),
        .rewind    (rd_en && bus_addr == OFS_CTL),
        .cpu_rdata (blk_rdata),
        .eng_addr  (eng_buf_addr),
        .eng_we    (eng_buf_we && busy),
        .eng_wdata (eng_buf_wdata),
        .eng_rdata (eng_buf_rdata)
    );

    // Configuration registers: frozen while a transaction runs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            proto_q  <= '0;
            pec_en_q <= 1'b0;
            cmd_q    <= '0;
            adr_q    <= '0;
            d0_q     <= '0;
            d1_q     <= '0;
            pec_q    <= '0;
            axc_q    <= '0;
        end else begin
            if (cfg_we) begin
                case (bus_addr)
                    OFS_CTL: begin
                        proto_q  <= bus_wdata[CTL_PR_HI:CTL_PR_LO];
                        pec_en_q <= bus_wdata[CTL_PEC];
                    end
                    OFS_CMD: cmd_q <= bus_wdata;
                    OFS_ADR: adr_q <= bus_wdata;
                    OFS_D0:  d0_q  <= bus_wdata;
                    OFS_D1:  d1_q  <= bus_wdata;
                    OFS_PEC: pec_q <= bus_wdata;
                    OFS_AXC: axc_q <= bus_wdata[1:0];
                    default: ;
                endcase
            end
            if (fin.ok && adr_q[0]) begin
                d0_q <= eng_rdata0;
                d1_q <= eng_rdata1;
            end
        end
    end

    // Sticky status: a set in the same cycle as a clear wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_bd    <= 1'b0;
            st_inuse <= 1'b0;
            st_alert <= 1'b0;
            st_fail  <= 1'b0;
            st_bus   <= 1'b0;
            st_dev   <= 1'b0;
            st_done  <= 1'b0;
            axs_pec  <= 1'b0;
        end else begin
            st_bd    <= (st_bd    && !st_clr[ST_BDONE]) || eng_byte_done;
            st_inuse <= (st_inuse && !st_clr[ST_INUSE]) || (rd_en && bus_addr == OFS_STAT);
            st_alert <= (st_alert && !st_clr[ST_ALERT]) || alert_in;
            st_fail  <= (st_fail  && !st_clr[ST_FAIL])  || fin.kill;
            st_bus   <= (st_bus   && !st_clr[ST_BUS])   || fin.arb;
            st_dev   <= (st_dev   && !st_clr[ST_DEV])   || fin.nack || fin.pec;
            st_done  <= (st_done  && !st_clr[ST_DONE])  || fin.ok;
            axs_pec  <= (axs_pec  && !(wr_en && bus_addr == OFS_AXS && bus_wdata[0])) || fin.pec;
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFS_STAT: bus_rdata = {st_bd, st_inuse, st_alert, st_fail, st_bus, st_dev, st_done, busy};
            OFS_CTL:  bus_rdata = {pec_en_q, 1'b0, proto_q, 2'b00};
            OFS_CMD:  bus_rdata = cmd_q;
            OFS_ADR:  bus_rdata = adr_q;
            OFS_D0:   bus_rdata = d0_q;
            OFS_D1:   bus_rdata = d1_q;
            OFS_BLK:  bus_rdata = blk_rdata;
            OFS_PEC:  bus_rdata = pec_q;
            OFS_AXS:  bus_rdata = {7'b0, axs_pec};
            OFS_AXC:  bus_rdata = {6'b0, axc_q};
            default:  bus_rdata = 8'h00;
        endcase
    end

    assign eng_proto    = proto_q;
    assign eng_pec_en   = pec_en_q;
    assign eng_slave    = adr_q[7:1];
    assign eng_dir_rd   = adr_q[0];
    assign eng_cmd      = cmd_q;
    assign eng_d0       = d0_q;
    assign eng_d1       = d1_q;
    assign eng_pec_byte = pec_q;
    assign eng_crc_chk  = axc_q[0];
    assign eng_buf32    = axc_q[1];

    // R4
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (st_done || st_dev || st_bus || st_fail))
        else $error("busy fell without an outcome flag");

    // R4
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fin))
        else $error("more than one outcome in a cycle");

    // R8
    w1c_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == OFS_STAT && bus_wdata == 8'h00 && !eng_byte_done && !alert_in && fin == '0)
        |=> ({st_bd, st_alert, st_fail, st_bus, st_dev, st_done} ==
             $past({st_bd, st_alert, st_fail, st_bus, st_dev, st_done})))
        else $error("zero write changed a status flag");

    // R7
    cmd_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && bus_addr == OFS_CMD) |=> $stable(cmd_q))
        else $error("command changed while busy");

    // R5
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin.ok && adr_q[0]) |=> (d0_q == $past(eng_rdata0) && d1_q == $past(eng_rdata1)))
        else $error("read data not captured");

endmodule

// File: tb/test_smbh_regfront.sv
module test_smbh_regfront;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int IW = 3;

    localparam logic [3:0] A_STAT = 4'd0, A_CTL = 4'd2, A_CMD = 4'd3, A_ADR = 4'd4,
                           A_D0 = 4'd5, A_D1 = 4'd6, A_BLK = 4'd7, A_PEC = 4'd8,
                           A_AXS = 4'd12, A_AXC = 4'd13;
    localparam logic [3:0] PROTOS [9] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hD, 4'hE};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic alert_in = 1'b0;
    logic eng_start, eng_abort, eng_pec_en, eng_dir_rd, eng_crc_chk, eng_buf32;
    logic [3:0] eng_proto;
    logic [6:0] eng_slave;
    logic [7:0] eng_cmd, eng_d0, eng_d1, eng_pec_byte, eng_buf_rdata;
    logic eng_done = 1'b0, eng_byte_done = 1'b0, eng_buf_we = 1'b0;
    logic [1:0] eng_result = '0;
    logic [7:0] eng_rdata0 = '0, eng_rdata1 = '0, eng_buf_wdata = '0;
    logic [IW-1:0] eng_buf_addr = '0;

    int n_vec = 0;
    int n_bad = 0;
    logic abort_seen;
    logic [7:0] q;

    always #(CLK_PERIOD/2) clk = ~clk;

    smbh_regfront #(.BUF_DEPTH(DEPTH)) i_smbh_regfront (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alert_in(alert_in),
        .eng_start(eng_start), .eng_abort(eng_abort), .eng_proto(eng_proto),
        .eng_pec_en(eng_pec_en), .eng_slave(eng_slave), .eng_dir_rd(eng_dir_rd),
        .eng_cmd(eng_cmd), .eng_d0(eng_d0), .eng_d1(eng_d1),
        .eng_pec_byte(eng_pec_byte), .eng_crc_chk(eng_crc_chk), .eng_buf32(eng_buf32),
        .eng_done(eng_done), .eng_result(eng_result), .eng_byte_done(eng_byte_done),
        .eng_rdata0(eng_rdata0), .eng_rdata1(eng_rdata1),
        .eng_buf_addr(eng_buf_addr), .eng_buf_we(eng_buf_we),
        .eng_buf_wdata(eng_buf_wdata), .eng_buf_rdata(eng_buf_rdata)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // All bus tasks start at a falling edge and end at the next one.
    task automatic bus_cycle(input logic w, input logic [3:0] a, input logic [7:0] d,
                             output logic [7:0] r);
        bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
        #1;
        r = bus_rdata;
        abort_seen = eng_abort;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        logic [7:0] dummy;
        bus_cycle(1'b1, a, d, dummy);
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] r);
        bus_cycle(1'b0, a, 8'h00, r);
    endtask

    task automatic finish(input logic [1:0] res, input logic [7:0] r0, input logic [7:0] r1);
        eng_done = 1'b1; eng_result = res; eng_rdata0 = r0; eng_rdata1 = r1;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    task automatic sweep();
        logic [7:0] r;
        logic [7:0] exps;
        for (int pi = 0; pi < 9; pi++) begin
            for (int res = 0; res < 4; res++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    logic [6:0] slave;
                    logic [7:0] cmdv, r0, r1;
                    slave = 7'(16 + pi * 4 + res);
                    cmdv  = 8'(pi * 16 + res * 2 + dir);
                    r0    = 8'hA5 ^ 8'(pi);
                    r1    = 8'h5A + 8'(res);
                    wr(A_ADR, {slave, 1'(dir)});
                    wr(A_CMD, cmdv);
                    wr(A_D0, 8'h11);
                    wr(A_D1, 8'h22);
                    wr(A_CTL, {1'(res), 1'b1, PROTOS[pi], 2'b00});
                    check("R3 start strobe", {7'b0, eng_start}, 8'h01);
                    check("R3 protocol", {4'b0, eng_proto}, {4'b0, PROTOS[pi]});
                    check("R3 pec enable", {7'b0, eng_pec_en}, 8'(res & 1));
                    check("R3 slave", {1'b0, eng_slave}, {1'b0, slave});
                    check("R3 direction", {7'b0, eng_dir_rd}, 8'(dir));
                    check("R3 command", eng_cmd, cmdv);
                    check("R3 data0 out", eng_d0, 8'h11);
                    rd(A_STAT, r);
                    check("R3 busy", r & 8'h01, 8'h01);
                    check("R3 single strobe", {7'b0, eng_start}, 8'h00);
                    finish(2'(res), r0, r1);
                    rd(A_STAT, r);
                    case (res)
                        0: exps = 8'h02;
                        1: exps = 8'h04;
                        2: exps = 8'h08;
                        default: exps = 8'h04;
                    endcase
                    check("R4 outcome flag", r & 8'hBF, exps);
                    rd(A_AXS, r);
                    check("R4 pec flag", r, (res == 3) ? 8'h01 : 8'h00);
                    rd(A_D0, r);
                    check("R5 data0", r, (res == 0 && dir == 1) ? r0 : 8'h11);
                    rd(A_D1, r);
                    check("R5 data1", r, (res == 0 && dir == 1) ? r1 : 8'h22);
                    wr(A_STAT, 8'hFF);
                    wr(A_AXS, 8'h01);
                end
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R3 watchdog: actual hung expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_STAT, q); check("R1 status", q, 8'h00);
        rd(A_CTL, q);  check("R1 control", q, 8'h00);
        rd(A_CMD, q);  check("R1 command", q, 8'h00);
        rd(A_ADR, q);  check("R1 address", q, 8'h00);
        rd(A_D0, q);   check("R1 data0", q, 8'h00);
        rd(A_D1, q);   check("R1 data1", q, 8'h00);
        rd(A_BLK, q);  check("R1 block", q, 8'h00);
        rd(A_PEC, q);  check("R1 pec", q, 8'h00);
        rd(A_AXS, q);  check("R1 aux status", q, 8'h00);
        rd(A_AXC, q);  check("R1 aux control", q, 8'h00);
        check("R1 strobes", {6'b0, eng_start, eng_abort}, 8'h00);
        wr(A_STAT, 8'h40);

        // R2 register map
        wr(A_CMD, 8'h3C); rd(A_CMD, q); check("R2 command", q, 8'h3C);
        wr(A_ADR, 8'hA5); rd(A_ADR, q); check("R2 address", q, 8'hA5);
        wr(A_D0, 8'h5A);  rd(A_D0, q);  check("R2 data0", q, 8'h5A);
        wr(A_D1, 8'hC3);  rd(A_D1, q);  check("R2 data1", q, 8'hC3);
        wr(A_PEC, 8'h96); rd(A_PEC, q); check("R2 pec", q, 8'h96);
        check("R2 pec out", eng_pec_byte, 8'h96);
        wr(A_AXC, 8'hFF); rd(A_AXC, q); check("R2 aux control", q, 8'h03);
        check("R2 aux outs", {6'b0, eng_buf32, eng_crc_chk}, 8'h03);
        wr(A_CTL, 8'hBC); rd(A_CTL, q); check("R2 control", q, 8'hBC);
        wr(A_AXC, 8'h00); wr(A_CTL, 8'h00);

        // R3 R4 R5 sweep of protocol x outcome x direction
        sweep();

        // R6 kill while busy
        wr(A_CTL, 8'h54);
        @(negedge clk);
        wr(A_CTL, 8'h02);
        check("R6 abort strobe", {7'b0, abort_seen}, 8'h01);
        rd(A_STAT, q); check("R6 failed", q & 8'hBF, 8'h10);
        finish(2'd0, 8'hEE, 8'hEE);
        rd(A_STAT, q); check("R6 late completion", q & 8'hBF, 8'h10);
        rd(A_CTL, q);  check("R6 control kept", q, 8'h14);
        wr(A_STAT, 8'hFF);
        // R6 kill while idle
        wr(A_CTL, 8'h02);
        check("R6 idle abort", {7'b0, abort_seen}, 8'h00);
        rd(A_STAT, q); check("R6 idle kill", q & 8'hBF, 8'h00);

        // R7 writes while busy ignored
        wr(A_CMD, 8'h55); wr(A_D0, 8'h33); wr(A_ADR, 8'h20);
        wr(A_CTL, 8'h48);
        @(negedge clk);
        wr(A_CMD, 8'h99); wr(A_D0, 8'h44); wr(A_AXC, 8'h03);
        wr(A_CTL, 8'h54);
        check("R7 no restart", {7'b0, eng_start}, 8'h00);
        check("R7 protocol held", {4'b0, eng_proto}, 8'h02);
        finish(2'd0, 8'h77, 8'h88);
        rd(A_CMD, q); check("R7 command held", q, 8'h55);
        rd(A_D0, q);  check("R7 data0 held", q, 8'h33);
        rd(A_AXC, q); check("R7 aux held", q, 8'h00);
        rd(A_CTL, q); check("R7 control held", q, 8'h08);
        rd(A_STAT, q); check("R7 done", q & 8'hBF, 8'h02);

        // R8 write-one-clear
        wr(A_STAT, 8'h00); rd(A_STAT, q); check("R8 zero write", q & 8'hBF, 8'h02);
        wr(A_STAT, 8'h02); rd(A_STAT, q); check("R8 one write", q & 8'hBF, 8'h00);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 8'h80; eng_byte_done = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; eng_byte_done = 1'b0;
        rd(A_STAT, q); check("R8 set wins", q & 8'hBF, 8'h80);
        wr(A_STAT, 8'hFF);

        // R11 byte done
        eng_byte_done = 1'b1; @(negedge clk); eng_byte_done = 1'b0;
        rd(A_STAT, q); check("R11 byte done", q & 8'hBF, 8'h80);
        wr(A_STAT, 8'h80); rd(A_STAT, q); check("R11 cleared", q & 8'hBF, 8'h00);

        // R10 alert
        alert_in = 1'b1; @(negedge clk); alert_in = 1'b0;
        rd(A_STAT, q); check("R10 alert", q & 8'hBF, 8'h20);
        wr(A_STAT, 8'h20); rd(A_STAT, q); check("R10 cleared", q & 8'hBF, 8'h00);

        // R9 in-use semaphore
        wr(A_STAT, 8'h40);
        rd(A_STAT, q); check("R9 first read", q & 8'h40, 8'h00);
        rd(A_STAT, q); check("R9 second read", q & 8'h40, 8'h40);
        wr(A_STAT, 8'h40);
        rd(A_STAT, q); check("R9 released", q & 8'h40, 8'h00);

        // R12 block buffer enabled
        wr(A_AXC, 8'h02);
        rd(A_CTL, q);
        for (int i = 0; i < DEPTH; i++) wr(A_BLK, 8'hA0 + 8'(i));
        rd(A_CTL, q);
        for (int i = 0; i < DEPTH; i++) begin
            rd(A_BLK, q); check("R12 sequential read", q, 8'hA0 + 8'(i));
        end
        rd(A_BLK, q); check("R12 wrap", q, 8'hA0);
        eng_buf_addr = 3'd3; #1;
        check("R12 engine read", eng_buf_rdata, 8'hA3);
        wr(A_CTL, 8'h54);
        eng_buf_we = 1'b1; eng_buf_addr = 3'd5; eng_buf_wdata = 8'h5C;
        @(negedge clk);
        eng_buf_we = 1'b0;
        finish(2'd0, 8'h00, 8'h00);
        wr(A_STAT, 8'hFF);
        rd(A_CTL, q);
        for (int i = 0; i < 6; i++) rd(A_BLK, q);
        check("R12 engine write", q, 8'h5C);
        eng_buf_we = 1'b1; eng_buf_addr = 3'd1; eng_buf_wdata = 8'hEE;
        @(negedge clk);
        eng_buf_we = 1'b0; #1;
        check("R12 idle engine write", eng_buf_rdata, 8'hA1);
        // R12 buffer disabled
        @(negedge clk);
        wr(A_AXC, 8'h00);
        wr(A_BLK, 8'h77); wr(A_BLK, 8'h78);
        rd(A_BLK, q); check("R12 single entry", q, 8'h78);
        rd(A_BLK, q); check("R12 no step", q, 8'h78);
        eng_buf_addr = 3'd0; #1; check("R12 entry zero", eng_buf_rdata, 8'h78);
        eng_buf_addr = 3'd1; #1; check("R12 entry one kept", eng_buf_rdata, 8'hA1);

        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule